// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave on a two-wire serial bus. It runs on a fast system clock and oversamples the bus clock and data lines. It drives the data line only through an active-high pull-down enable, so the pad stays open-drain. The block recognises bus start and stop conditions and compares the first byte with a fixed 7-bit device address. It then moves bytes between the bus and a small six-byte register file.

A write transaction carries a pointer byte followed by any number of data bytes. A read transaction returns bytes beginning at the current pointer. In both directions the pointer steps through the six locations and wraps around.

The registers appear on dedicated outputs. These are a 32-bit count value, a control byte and a charge-configuration byte. The charge byte is also decoded into a charge enable, a diode choice and a resistor choice. An active power-fail input shuts the bus out of the register file.

Top module: `twowire_regslave`

## Requirements
- R1: A START (data line falls while the clock line is high) begins address reception from any state. A STOP (data line rises while the clock line is high) returns the slave to idle, and bytes clocked after a STOP draw no acknowledge until the next START.
- R2: Bits are taken on the rising edge of the clock line, most significant bit first. The slave changes its pull-down only while the clock line is low.
- R3: The first byte after START carries the device address in bits 7..1 (parameter DEV_ADDR, default 7'h68) and the direction in bit 0 (1 = read). On a match the slave pulls the data line low for the ninth clock.
- R4: After an address that does not match, the slave gives no acknowledge and ignores all later bytes until the next START. The registers stay unchanged.
- R5: In a write, the byte after the address loads the pointer. A pointer value of 06h or more loads 00h. Every later byte is stored at the pointer, and the slave acknowledges each of these bytes.
- R6: After each data byte is written or read, the pointer increments, and it goes from 05h back to 00h.
- R7: A read returns the byte at the pointer. A master acknowledge continues with the next byte. A master non-acknowledge makes the slave release the data line and send nothing more until a START.
- R8: Locations 00h..03h form count_o, with 00h as the least significant byte. Location 04h is ctrl_o and location 05h is the charge byte. All six locations reset to 00h.
- R9: Charging is enabled only when charge-byte bits 7..4 equal 1010, bits 3..2 equal 01 (no diode) or 10 (diode), and bits 1..0 are nonzero. When enabled, chg_res_o equals bits 1..0 (01 low, 10 middle, 11 high) and chg_diode_o is 1 for 10. When disabled, all three charge outputs are 0.
- R10: While pwr_fail_i is high, no byte is acknowledged, no register changes and the slave goes idle.
- R11: A repeated START in the middle of a transaction restarts address decoding and keeps the pointer. Writing a pointer and then reading after a repeated START therefore reads from that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| pwr_fail_i | input | 1 | High while supply is out of tolerance; blocks access |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| count_o | output | 32 | Count value from locations 00h..03h |
| ctrl_o | output | 8 | Control byte, location 04h |
| chg_en_o | output | 1 | Charging enabled |
| chg_diode_o | output | 1 | Series diode selected |
| chg_res_o | output | 2 | Resistor choice, 0 when disabled |

## Verification
The bench runs write bursts with random start pointer, length and data, each followed by a full read-back from 00h. Because these bursts start at every location and often run past 05h, they separate a correct pointer wrap from an off-by-one, and a byte-order error on count_o from a storage error. Directed cases add several other conditions: a non-matching address, a power-fail window, a STOP right after the address, an out-of-range pointer and a read that the master ends with a non-acknowledge. Each of these has its own expected outcome for acknowledge and register contents. A list of charge-byte values, including a wrong key, diode codes 00 and 11 and resistor code 00, separates the exact-key decode from partial decodes.

// File: rtl/twr_pkg.sv
package twr_pkg;
    localparam int DATA_W    = 8;
    localparam int NREG      = 6;
    localparam int PTR_W     = $clog2(NREG);
    localparam int CNT_BYTES = 4;
    localparam int CTRL_IDX  = 4;
    localparam int TRK_IDX   = 5;
    localparam int BIT_W     = $clog2(DATA_W + 1);
    localparam logic [3:0] TRK_KEY = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ACK_A, ST_PTR, ST_ACK_P,
        ST_WR, ST_ACK_W, ST_RD, ST_RACK
    } bus_st_e;

    typedef struct packed {
        bus_st_e             st;
        logic [DATA_W-1:0]   sh;
        logic [BIT_W-1:0]    bits;
        logic [PTR_W-1:0]    ptr;
        logic                rw;
        logic                oe;
        logic                mack;
        logic                scl_p;
        logic                sda_p;
    } bus_q_t;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0] chain_q [W];

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= '1;
            else        chain_q[i] <= {chain_q[i][STAGES-2:0], din[i]};
        end
        assign dout[i] = chain_q[i][STAGES-1];
    end
endmodule

// File: rtl/twr_bus.sv
module twr_bus
    import twr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              pwr_fail,
    input  logic [DATA_W-1:0] rdata,
    output logic              we,
    output logic [PTR_W-1:0]  waddr,
    output logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  raddr,
    output logic              sda_oe
);
    localparam logic [BIT_W-1:0] FULL = BIT_W'(DATA_W);

    bus_q_t q, d;
    logic   scl_rise, scl_fall, start_c, stop_c, we_c;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NREG - 1)) ? '0 : p + 1'b1;
    endfunction

    assign scl_rise = scl & ~q.scl_p;
    assign scl_fall = ~scl & q.scl_p;
    assign start_c  = scl & q.scl_p & q.sda_p & ~sda;
    assign stop_c   = scl & q.scl_p & ~q.sda_p & sda;

    always_comb begin
        d       = q;
        we_c    = 1'b0;
        d.scl_p = scl;
        d.sda_p = sda;
        if (start_c) begin
            d.st = ST_ADDR; d.bits = '0; d.oe = 1'b0;
        end else if (stop_c) begin
            d.st = ST_IDLE; d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_PTR, ST_WR: begin
                    if (scl_rise && q.bits != FULL) begin
                        d.sh   = {q.sh[DATA_W-2:0], sda};
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == FULL) begin
                        d.bits = '0;
                        if (pwr_fail) begin
                            d.st = ST_IDLE;
                        end else if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.rw = q.sh[0]; d.oe = 1'b1; d.st = ST_ACK_A;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_PTR) begin
                            d.ptr = (q.sh < DATA_W'(NREG)) ? q.sh[PTR_W-1:0] : '0;
                            d.oe  = 1'b1;
                            d.st  = ST_ACK_P;
                        end else begin
                            we_c  = 1'b1;
                            d.ptr = ptr_step(q.ptr);
                            d.oe  = 1'b1;
                            d.st  = ST_ACK_W;
                        end
                    end
                end
                ST_ACK_A: if (scl_fall) begin
                    if (q.rw) begin
                        d.sh = rdata; d.oe = ~rdata[DATA_W-1];
                        d.ptr = ptr_step(q.ptr); d.st = ST_RD;
                    end else begin
                        d.oe = 1'b0; d.st = ST_PTR;
                    end
                end
                ST_ACK_P, ST_ACK_W: if (scl_fall) begin
                    d.oe = 1'b0; d.st = ST_WR;
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == FULL) begin
                        d.oe = 1'b0; d.bits = '0; d.st = ST_RACK;
                    end else if (scl_fall && q.bits != '0) begin
                        d.sh = {q.sh[DATA_W-2:0], 1'b0};
                        d.oe = ~q.sh[DATA_W-2];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda;
                    end else if (scl_fall) begin
                        if (q.mack && !pwr_fail) begin
                            d.sh = rdata; d.oe = ~rdata[DATA_W-1];
                            d.ptr = ptr_step(q.ptr); d.st = ST_RD;
                        end else begin
                            d.oe = 1'b0; d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign we     = we_c;
    assign waddr  = q.ptr;
    assign wdata  = q.sh;
    assign raddr  = q.ptr;
    assign sda_oe = q.oe;
endmodule

// File: rtl/twr_regs.sv
module twr_regs
    import twr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [PTR_W-1:0]       waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [PTR_W-1:0]       raddr,
    output logic [DATA_W-1:0]      rdata,
    output logic [NREG*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] mem_q [NREG];
    logic [DATA_W-1:0] mem_d [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_byte
        always_comb begin
            mem_d[i] = (we && waddr == PTR_W'(i)) ? wdata : mem_q[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
        assign flat[i*DATA_W +: DATA_W] = mem_q[i];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (raddr == PTR_W'(i)) rdata = mem_q[i];
        end
    end
endmodule

// File: rtl/twr_trickle.sv
module twr_trickle
    import twr_pkg::*;
(
    input  logic [DATA_W-1:0] cfg,
    output logic              en,
    output logic              diode,
    output logic [1:0]        res
);
    logic key_ok, ds_ok, rs_ok;

    always_comb begin
        key_ok = (cfg[7:4] == TRK_KEY);
        ds_ok  = (cfg[3:2] == 2'b01) || (cfg[3:2] == 2'b10);
        rs_ok  = (cfg[1:0] != 2'b00);
        en     = key_ok && ds_ok && rs_ok;
        diode  = en && (cfg[3:2] == 2'b10);
        res    = en ? cfg[1:0] : 2'b00;
    end
endmodule

// File: rtl/twowire_regslave.sv
module twowire_regslave
    import twr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        pwr_fail_i,
    output logic        sda_oe_o,
    output logic [31:0] count_o,
    output logic [7:0]  ctrl_o,
    output logic        chg_en_o,
    output logic        chg_diode_o,
    output logic [1:0]  chg_res_o
);
    logic [1:0]               sync_out;
    logic                     scl_sync, sda_sync, wr_en;
    logic [PTR_W-1:0]         wr_ptr, rd_ptr;
    logic [DATA_W-1:0]        wr_byte, rd_byte, trk_byte;
    logic [NREG*DATA_W-1:0]   reg_flat;

    twr_sync #(.W(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(sync_out)
    );
    assign scl_sync = sync_out[1];
    assign sda_sync = sync_out[0];

    twr_bus #(.DEV_ADDR(DEV_ADDR)) u_bus (
        .clk(clk), .rst_n(rst_n), .scl(scl_sync), .sda(sda_sync),
        .pwr_fail(pwr_fail_i), .rdata(rd_byte), .we(wr_en), .waddr(wr_ptr),
        .wdata(wr_byte), .raddr(rd_ptr), .sda_oe(sda_oe_o)
    );

    twr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_ptr), .wdata(wr_byte),
        .raddr(rd_ptr), .rdata(rd_byte), .flat(reg_flat)
    );

    assign count_o  = reg_flat[CNT_BYTES*DATA_W-1:0];
    assign ctrl_o   = reg_flat[CTRL_IDX*DATA_W +: DATA_W];
    assign trk_byte = reg_flat[TRK_IDX*DATA_W +: DATA_W];

    twr_trickle u_trk (
        .cfg(trk_byte), .en(chg_en_o), .diode(chg_diode_o), .res(chg_res_o)
    );
endmodule

// File: rtl/twr_checks.sv
module twr_checks
    import twr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             pwr_fail,
    input logic [31:0]      count,
    input logic [7:0]       ctrl,
    input logic [7:0]       trk,
    input logic [PTR_W-1:0] ptr,
    input logic             en,
    input logic             diode,
    input logic [1:0]       res
);
    p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);

    p_pf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> ($stable(count) && $stable(ctrl) && $stable(trk)));

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < PTR_W'(NREG));

    p_diode_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        diode |-> en);

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (res == 2'b00 && !diode));

    p_key_needed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (trk[7:4] == TRK_KEY && res != 2'b00));
endmodule

bind twowire_regslave twr_checks u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_sync), .sda_oe(sda_oe_o),
    .pwr_fail(pwr_fail_i), .count(count_o), .ctrl(ctrl_o), .trk(trk_byte),
    .ptr(rd_ptr), .en(chg_en_o), .diode(chg_diode_o), .res(chg_res_o)
);

// File: tb/twowire_regslave_test.sv
module twowire_regslave_test;
    localparam logic [6:0] DEV = 7'h68;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic pwr_fail = 1'b0;
    logic sda_oe;
    logic [31:0] count;
    logic [7:0] ctrl;
    logic en, diode;
    logic [1:0] res;
    wire sda_bus = m_sda & ~sda_oe;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] mregs [6];
    int mptr = 0;

    always #2 clk = ~clk;

    twowire_regslave #(.DEV_ADDR(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .pwr_fail_i(pwr_fail), .sda_oe_o(sda_oe), .count_o(count),
        .ctrl_o(ctrl), .chg_en_o(en), .chg_diode_o(diode), .chg_res_o(res)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic qd();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic bstart();
        m_sda = 1'b1; qd(); scl = 1'b1; qd(); m_sda = 1'b0; qd(); scl = 1'b0; qd();
    endtask

    task automatic bstop();
        m_sda = 1'b0; qd(); scl = 1'b1; qd(); m_sda = 1'b1; qd();
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qd(); scl = 1'b1; qd(); qd(); scl = 1'b0;
        end
        m_sda = 1'b1; qd(); scl = 1'b1; qd(); ack = ~sda_bus; qd(); scl = 1'b0; qd();
    endtask

    task automatic recv(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qd(); scl = 1'b1; qd(); b[i] = sda_bus; qd(); scl = 1'b0;
        end
        m_sda = ~mack; qd(); scl = 1'b1; qd(); qd(); scl = 1'b0; qd(); m_sda = 1'b1;
    endtask

    function automatic int pstep(input int p);
        return (p == 5) ? 0 : p + 1;
    endfunction

    function automatic logic [3:0] exp_trk(input logic [7:0] v);
        logic e;
        e = (v[7:4] == 4'hA) && (v[3:2] == 2'b01 || v[3:2] == 2'b10) && (v[1:0] != 2'b00);
        return {e, e && v[3:2] == 2'b10, e ? v[1:0] : 2'b00};
    endfunction

    task automatic check_outputs(input string tag);
        check({tag, " R8 count"}, count, {mregs[3], mregs[2], mregs[1], mregs[0]});
        check({tag, " R8 ctrl"}, {24'd0, ctrl}, {24'd0, mregs[4]});
        check({tag, " R9 charge"}, {28'd0, en, diode, res}, {28'd0, exp_trk(mregs[5])});
    endtask

    task automatic write_tx(input int p, input int n, input logic [7:0] data [8]);
        logic ack;
        bstart();
        send({DEV, 1'b0}, ack); check("R3 addr ack", {31'd0, ack}, 32'd1);
        send(8'(p), ack);       check("R5 ptr ack", {31'd0, ack}, 32'd1);
        mptr = (p > 5) ? 0 : p;
        for (int k = 0; k < n; k++) begin
            send(data[k], ack);
            check("R5 data ack", {31'd0, ack}, 32'd1);
            mregs[mptr] = data[k];
            mptr = pstep(mptr);
        end
        bstop();
    endtask

    task automatic read_tx(input int n, input string tag);
        logic ack;
        logic [7:0] b;
        bstart();
        send({DEV, 1'b1}, ack); check({tag, " R3 read ack"}, {31'd0, ack}, 32'd1);
        for (int k = 0; k < n; k++) begin
            recv(k < n - 1, b);
            check({tag, " R2 R7 read data"}, {24'd0, b}, {24'd0, mregs[mptr]});
            mptr = pstep(mptr);
        end
        bstop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R1 watchdog expired got running exp done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] dat [8];
        logic ack;
        logic [7:0] b;
        logic [7:0] tv [11];
        for (int i = 0; i < 6; i++) mregs[i] = 8'h00;
        void'($urandom(32'd4242));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        qd();
        check_outputs("reset");
        check("R8 reset oe", {31'd0, sda_oe}, 32'd0);

        // R5 R6: eight bytes from pointer 0 wrap onto 00h/01h
        for (int k = 0; k < 8; k++) dat[k] = 8'(8'h11 * (k + 1));
        write_tx(0, 8, dat);
        check_outputs("R6 wrap write");

        // R11: pointer 04h, repeated START, read four bytes across the wrap
        bstart();
        send({DEV, 1'b0}, ack);
        send(8'h04, ack);
        check("R11 ptr ack", {31'd0, ack}, 32'd1);
        mptr = 4;
        bstart();
        send({DEV, 1'b1}, ack);
        check("R11 restart read ack", {31'd0, ack}, 32'd1);
        for (int k = 0; k < 4; k++) begin
            recv(k < 3, b);
            check("R11 R6 read after restart", {24'd0, b}, {24'd0, mregs[mptr]});
            mptr = pstep(mptr);
        end
        bstop();
        check("R7 oe released after nack", {31'd0, sda_oe}, 32'd0);

        // R4: foreign address, later bytes ignored
        bstart();
        send({7'h21, 1'b0}, ack);
        check("R4 no ack foreign", {31'd0, ack}, 32'd0);
        send(8'h00, ack);
        check("R4 ptr ignored", {31'd0, ack}, 32'd0);
        send(8'h5A, ack);
        check("R4 data ignored", {31'd0, ack}, 32'd0);
        bstop();
        check_outputs("R4");

        // R1: STOP right after address, then bytes without START
        bstart();
        send({DEV, 1'b0}, ack);
        check("R1 addr ack", {31'd0, ack}, 32'd1);
        bstop();
        send(8'h00, ack);
        check("R1 no ack after stop", {31'd0, ack}, 32'd0);
        send(8'hC3, ack);
        check("R1 no ack after stop data", {31'd0, ack}, 32'd0);
        bstop();
        check_outputs("R1");

        // R10: power-fail blocks access
        pwr_fail = 1'b1;
        bstart();
        send({DEV, 1'b0}, ack);
        check("R10 no ack in power fail", {31'd0, ack}, 32'd0);
        send(8'h00, ack);
        send(8'hEE, ack);
        check("R10 data ignored", {31'd0, ack}, 32'd0);
        bstop();
        pwr_fail = 1'b0;
        qd();
        check_outputs("R10");

        // R5: out-of-range pointer loads 00h
        dat[0] = 8'h9C;
        write_tx(7, 1, dat);
        check("R5 ptr above 05h", {24'd0, count[7:0]}, 32'h9C);

        // R9: charge byte decode
        tv = '{8'hA5, 8'hA9, 8'hA6, 8'hAA, 8'hA7, 8'hAB, 8'hA4, 8'hAC, 8'hA0, 8'hB5, 8'h25};
        for (int t = 0; t < 11; t++) begin
            dat[0] = tv[t];
            write_tx(5, 1, dat);
            check("R9 decode", {28'd0, en, diode, res}, {28'd0, exp_trk(tv[t])});
        end

        // R7: single byte read ended with nack, then bus still usable
        mptr = 0;
        dat[0] = 8'h00;
        bstart(); send({DEV, 1'b0}, ack); send(8'h02, ack); bstop();
        mptr = 2;
        read_tx(1, "R7 nack");
        check("R7 idle after nack", {31'd0, sda_oe}, 32'd0);

        // random bursts with full read-back
        for (int it = 0; it < 18; it++) begin
            int p, n;
            p = int'($urandom_range(0, 7));
            n = int'($urandom_range(1, 8));
            for (int k = 0; k < 8; k++) dat[k] = 8'($urandom);
            write_tx(p, n, dat);
            check_outputs("rand");
            bstart(); send({DEV, 1'b0}, ack); send(8'h00, ack); bstop();
            mptr = 0;
            read_tx(6, "rand R6");
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule